// File: doc/BRIEF.md
# Skip-Mask Instruction Fetch Sequencer

This block drives the program counter of a small processor core and applies a skip pattern to the instruction stream that follows it. Each bit of the pattern belongs to one upcoming instruction. A set bit suppresses that instruction and a clear bit lets it run. The pattern moves on by one bit for every instruction that is consumed. The core reports skip-load commands, taken branches and the write and flag enables of the instruction it has just decoded. The sequencer returns the PC of the current slot, tells the core whether the slot executes or is cancelled, and gates the enables to match.

There are three ways to load a pattern. A plain load cancels masked instructions one slot at a time. A fast load works the same way in shared memory, but in local memory it moves the PC straight past masked instructions. An execute-with-address load takes one operand that carries both a local-memory target and a pattern, and it branches to that target. The mask keeps being consumed across relative branches. When a fast sequence moves into shared memory, it drops to per-slot cancellation for the rest of its mask.

Every clock cycle is one instruction slot. The core offers no back-pressure, so all pins are plain level signals that are sampled once per cycle. There is no valid/ready handshake.

Top module: `skip_seq`

## Requirements
- R1: At reset the PC is 0 and the mask is empty. `skip_active` is 1 exactly when any mask bit is still pending. A slot whose mask bit 0 is 1 has `slot_cancel`=1 and `slot_go`=0. Bit 0 of a loaded pattern applies to the instruction that follows the load command, and the mask shifts right by one bit for each slot consumed.
- R2: In a cancelled slot, `wr_en` and `flag_en` are 0 in that same cycle. Any branch or skip command presented in that slot has no effect, so the PC moves by sequential rules only.
- R3: A plain load (`cmd_skip`, pattern on `cmd_arg`) takes effect at PC+1. The PC then steps by exactly 1 per cycle, and masked instructions show up as cancelled slots.
- R4: After a fast load (`cmd_fskip`), in local memory (PC below 2**LOCAL_AW, `local_region`=1), the PC passes over up to 7 consecutive masked instructions in one step and lands on the next enabled instruction.
- R5: Under a fast load, a run of 8 or more masked instructions first skips 7 of them. The next masked instruction then appears as one cancelled (idle) slot.
- R6: If bit 0 of a fast pattern is 1, the slot at PC+1 is cancelled. It is not jumped over.
- R7: `cmd_exec` branches to `cmd_arg[8:0]` and loads `cmd_arg[31:9]` as a fast pattern. Bit 0 of that pattern applies to the instruction at the target.
- R8: A taken relative branch (`br_take`=1, `br_abs`=0, destination `br_target`) consumes one mask bit. Under a fast pattern in local memory, the PC lands on the first enabled instruction at or beyond the target.
- R9: A taken absolute branch (`br_abs`=1) from local memory raises `abs_err` in the same cycle if the instruction after it is masked (mask bit 1). The landing slot of an absolute branch is never fast-skipped.
- R10: Once a fast sequence has a PC in shared memory, it stops fast skipping for the rest of its mask. This holds even after the PC returns to local memory.
- R11: A new load command in an executing slot replaces any pattern that is still pending. If several commands are raised together, `cmd_exec` wins over `cmd_fskip`, and `cmd_fskip` wins over `cmd_skip`. A command also overrides a branch raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_skip | input | 1 | Current instruction is a plain skip load |
| cmd_fskip | input | 1 | Current instruction is a fast skip load |
| cmd_exec | input | 1 | Current instruction is an execute-with-address load |
| cmd_arg | input | 32 | Pattern, or target and pattern for execute |
| br_take | input | 1 | Current instruction takes a branch |
| br_abs | input | 1 | Branch is absolute |
| br_target | input | 16 | Branch destination address |
| dec_wr_en | input | 1 | Decoded register write enable |
| dec_flag_en | input | 1 | Decoded flag update enable |
| pc | output | 16 | Address of the current slot |
| slot_go | output | 1 | Current slot executes |
| slot_cancel | output | 1 | Current slot is cancelled |
| local_region | output | 1 | PC lies in local memory |
| wr_en | output | 1 | Gated write enable |
| flag_en | output | 1 | Gated flag enable |
| abs_err | output | 1 | Absolute branch with masked follower |
| skip_active | output | 1 | Mask bits still pending |

## Verification
Some properties are checked on every cycle. A cancelled slot must gate the write and flag enables. A cancelled slot, and any slot in shared memory without a branch or command, advances the PC by exactly 1. A local step with no branch or command never moves more than eight addresses. `abs_err` appears only alongside a live absolute branch from local memory. An execute load must land on its 9-bit target. Other behaviour shows only across whole scenarios. These are the exact landing addresses of fast skips, the single idle slot that a run of eight produces, the cancelled first slot, the mask carried across relative branches, and the loss of fast mode after a visit to shared memory. The bench's directed sequences and its reference model check these.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_PLAIN = 2'd1,
    LD_FAST  = 2'd2,
    LD_EXEC  = 2'd3
  } load_e;
endpackage

// File: rtl/skip_cmd_dec.sv
module skip_cmd_dec
  import skip_seq_pkg::*;
(
  input  logic  live,
  input  logic  cmd_skip,
  input  logic  cmd_fskip,
  input  logic  cmd_exec,
  input  logic  br_take,
  input  logic  dec_wr_en,
  input  logic  dec_flag_en,
  output load_e load_kind,
  output logic  br_live,
  output logic  wr_en,
  output logic  flag_en
);
  always_comb begin
    load_kind = LD_NONE;
    if (live) begin
      if (cmd_exec)       load_kind = LD_EXEC;
      else if (cmd_fskip) load_kind = LD_FAST;
      else if (cmd_skip)  load_kind = LD_PLAIN;
    end
  end

  assign br_live = live && br_take && (load_kind == LD_NONE);
  assign wr_en   = live && dec_wr_en;
  assign flag_en = live && dec_flag_en;
endmodule

// File: rtl/skip_run_len.sv
module skip_run_len #(
  parameter int MAXRUN = 7,
  localparam int RUNW  = $clog2(MAXRUN + 1)
) (
  input  logic [MAXRUN-1:0] vec,
  output logic [RUNW-1:0]   run
);
  logic [MAXRUN-1:0] prefix;

  assign prefix[0] = vec[0];
  for (genvar i = 1; i < MAXRUN; i++) begin : g_pre
    assign prefix[i] = prefix[i-1] & vec[i];
  end

  always_comb begin
    run = '0;
    for (int k = 0; k < MAXRUN; k++) begin
      run = run + RUNW'(prefix[k]);
    end
  end
endmodule

// File: rtl/skip_next_pc.sv
module skip_next_pc
  import skip_seq_pkg::*;
#(
  parameter int PCW      = 16,
  parameter int MASKW    = 32,
  parameter int LOCAL_AW = 10,
  parameter int EXEC_TW  = 9,
  parameter int MAXRUN   = 7,
  localparam int RUNW    = $clog2(MAXRUN + 1)
) (
  input  logic [PCW-1:0]   pc_q,
  input  logic [MASKW-1:0] mask_q,
  input  logic             fast_q,
  input  load_e            load_kind,
  input  logic [MASKW-1:0] cmd_arg,
  input  logic             br_live,
  input  logic             br_abs,
  input  logic [PCW-1:0]   br_target,
  output logic [PCW-1:0]   pc_n,
  output logic [MASKW-1:0] mask_n,
  output logic             fast_n
);
  logic [MASKW-1:0] mask_after;
  logic [PCW-1:0]   pc_seq;
  logic [PCW-1:0]   land;
  logic             land_local;
  logic             do_fast;
  logic [RUNW-1:0]  run;
  logic [RUNW-1:0]  step;

  function automatic logic is_local(input logic [PCW-1:0] a);
    return (a >> LOCAL_AW) == '0;
  endfunction

  assign mask_after = mask_q >> 1;
  assign pc_seq     = pc_q + PCW'(1);
  assign land       = br_live ? br_target : pc_seq;
  assign land_local = is_local(land);
  assign do_fast    = fast_q && land_local && !(br_live && br_abs);

  skip_run_len #(.MAXRUN(MAXRUN)) u_run (
    .vec (mask_after[MAXRUN-1:0]),
    .run (run)
  );

  assign step = do_fast ? run : '0;

  always_comb begin
    pc_n   = pc_seq;
    mask_n = mask_after;
    fast_n = 1'b0;
    unique case (load_kind)
      LD_PLAIN: begin
        pc_n   = pc_seq;
        mask_n = cmd_arg;
        fast_n = 1'b0;
      end
      LD_FAST: begin
        pc_n   = pc_seq;
        mask_n = cmd_arg;
        fast_n = is_local(pc_seq);
      end
      LD_EXEC: begin
        pc_n   = PCW'(cmd_arg[EXEC_TW-1:0]);
        mask_n = cmd_arg >> EXEC_TW;
        fast_n = is_local(PCW'(cmd_arg[EXEC_TW-1:0]));
      end
      default: begin
        pc_n   = land + PCW'(step);
        mask_n = mask_after >> step;
        fast_n = fast_q && is_local(land + PCW'(step));
      end
    endcase
  end
endmodule

// File: rtl/skip_seq.sv
module skip_seq
  import skip_seq_pkg::*;
#(
  parameter int PCW      = 16,
  parameter int MASKW    = 32,
  parameter int LOCAL_AW = 10,
  parameter int EXEC_TW  = 9,
  parameter int MAXRUN   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_skip,
  input  logic             cmd_fskip,
  input  logic             cmd_exec,
  input  logic [MASKW-1:0] cmd_arg,
  input  logic             br_take,
  input  logic             br_abs,
  input  logic [PCW-1:0]   br_target,
  input  logic             dec_wr_en,
  input  logic             dec_flag_en,
  output logic [PCW-1:0]   pc,
  output logic             slot_go,
  output logic             slot_cancel,
  output logic             local_region,
  output logic             wr_en,
  output logic             flag_en,
  output logic             abs_err,
  output logic             skip_active
);
  logic [PCW-1:0]   pc_q, pc_n;
  logic [MASKW-1:0] mask_q, mask_n;
  logic             fast_q, fast_n;
  load_e            load_kind;
  logic             br_live;

  assign slot_cancel  = mask_q[0];
  assign slot_go      = !mask_q[0];
  assign local_region = (pc_q >> LOCAL_AW) == '0;
  assign skip_active  = |mask_q;
  assign pc           = pc_q;

  skip_cmd_dec u_dec (
    .live        (slot_go),
    .cmd_skip    (cmd_skip),
    .cmd_fskip   (cmd_fskip),
    .cmd_exec    (cmd_exec),
    .br_take     (br_take),
    .dec_wr_en   (dec_wr_en),
    .dec_flag_en (dec_flag_en),
    .load_kind   (load_kind),
    .br_live     (br_live),
    .wr_en       (wr_en),
    .flag_en     (flag_en)
  );

  skip_next_pc #(
    .PCW(PCW), .MASKW(MASKW), .LOCAL_AW(LOCAL_AW),
    .EXEC_TW(EXEC_TW), .MAXRUN(MAXRUN)
  ) u_next (
    .pc_q      (pc_q),
    .mask_q    (mask_q),
    .fast_q    (fast_q),
    .load_kind (load_kind),
    .cmd_arg   (cmd_arg),
    .br_live   (br_live),
    .br_abs    (br_abs),
    .br_target (br_target),
    .pc_n      (pc_n),
    .mask_n    (mask_n),
    .fast_n    (fast_n)
  );

  assign abs_err = br_live && br_abs && local_region && mask_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mask_q <= '0;
      fast_q <= 1'b0;
    end else begin
      pc_q   <= pc_n;
      mask_q <= mask_n;
      fast_q <= fast_n;
    end
  end
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
  parameter int PCW     = 16,
  parameter int MASKW   = 32,
  parameter int EXEC_TW = 9,
  parameter int MAXRUN  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_skip,
  input logic             cmd_fskip,
  input logic             cmd_exec,
  input logic [MASKW-1:0] cmd_arg,
  input logic             br_take,
  input logic             br_abs,
  input logic [PCW-1:0]   pc,
  input logic             slot_go,
  input logic             slot_cancel,
  input logic             local_region,
  input logic             wr_en,
  input logic             flag_en,
  input logic             abs_err,
  input logic             skip_active
);
  logic quiet;
  assign quiet = !br_take && !cmd_skip && !cmd_fskip && !cmd_exec;

  a_r1_cancel_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cancel |-> (skip_active && !slot_go));

  a_r2_cancel_gates_enables: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cancel |-> (!wr_en && !flag_en));

  a_r2_cancel_hub_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cancel && !local_region) |=> (pc == PCW'($past(pc) + 1'b1)));

  a_r10_hub_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_region && quiet) |=> (pc == PCW'($past(pc) + 1'b1)));

  a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (local_region && quiet) |=> (PCW'(pc - $past(pc)) <= PCW'(MAXRUN + 1)));

  a_r7_exec_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && slot_go) |=> (pc == PCW'($past(cmd_arg[EXEC_TW-1:0]))));

  a_r9_abs_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    abs_err |-> (br_take && br_abs && slot_go && local_region));
endmodule

bind skip_seq skip_seq_chk #(
  .PCW(PCW), .MASKW(MASKW), .EXEC_TW(EXEC_TW), .MAXRUN(MAXRUN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_skip     (cmd_skip),
  .cmd_fskip    (cmd_fskip),
  .cmd_exec     (cmd_exec),
  .cmd_arg      (cmd_arg),
  .br_take      (br_take),
  .br_abs       (br_abs),
  .pc           (pc),
  .slot_go      (slot_go),
  .slot_cancel  (slot_cancel),
  .local_region (local_region),
  .wr_en        (wr_en),
  .flag_en      (flag_en),
  .abs_err      (abs_err),
  .skip_active  (skip_active)
);

// File: tb/test_skip_seq.sv
`timescale 1ns/1ps
module test_skip_seq;
  localparam int PCW = 16;
  localparam int MW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_skip = 0, cmd_fskip = 0, cmd_exec = 0;
  logic [MW-1:0] cmd_arg = '0;
  logic          br_take = 0, br_abs = 0;
  logic [PCW-1:0] br_target = '0;
  logic          dec_wr_en = 0, dec_flag_en = 0;
  logic [PCW-1:0] pc;
  logic          slot_go, slot_cancel, local_region, wr_en, flag_en, abs_err, skip_active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [PCW-1:0] m_pc;
  logic [MW-1:0]  m_mask;
  bit             m_fast;

  always #2.5 clk = ~clk;

  skip_seq i_skip_seq (
    .clk(clk), .rst_n(rst_n), .cmd_skip(cmd_skip), .cmd_fskip(cmd_fskip),
    .cmd_exec(cmd_exec), .cmd_arg(cmd_arg), .br_take(br_take), .br_abs(br_abs),
    .br_target(br_target), .dec_wr_en(dec_wr_en), .dec_flag_en(dec_flag_en),
    .pc(pc), .slot_go(slot_go), .slot_cancel(slot_cancel),
    .local_region(local_region), .wr_en(wr_en), .flag_en(flag_en),
    .abs_err(abs_err), .skip_active(skip_active)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_loc(input logic [PCW-1:0] a);
    return a < 16'd1024;
  endfunction

  function automatic int ones_run(input logic [MW-1:0] v);
    int r = 0;
    while (r < 7 && v[r]) r++;
    return r;
  endfunction

  task automatic model_check_and_step();
    bit live, brl, cmd;
    logic [MW-1:0] after;
    logic [PCW-1:0] lnd;
    int n;
    live = !m_mask[0];
    chk("R1 pc", pc, m_pc);
    chk("R1 cancel", slot_cancel, m_mask[0]);
    chk("R1 active", skip_active, m_mask != 0);
    chk("R2 wr_en", wr_en, live & dec_wr_en);
    chk("R2 flag_en", flag_en, live & dec_flag_en);
    cmd = live && (cmd_exec || cmd_fskip || cmd_skip);
    brl = live && br_take && !cmd;
    chk("R9 abs_err", abs_err, brl && br_abs && is_loc(m_pc) && m_mask[1]);
    after = m_mask >> 1;
    if (live && cmd_exec) begin
      m_pc = PCW'(cmd_arg[8:0]); m_mask = cmd_arg >> 9; m_fast = 1;
    end else if (live && cmd_fskip) begin
      m_pc = m_pc + 1; m_mask = cmd_arg; m_fast = is_loc(m_pc);
    end else if (live && cmd_skip) begin
      m_pc = m_pc + 1; m_mask = cmd_arg; m_fast = 0;
    end else begin
      lnd = brl ? br_target : PCW'(m_pc + 1);
      n = (m_fast && is_loc(lnd) && !(brl && br_abs)) ? ones_run(after) : 0;
      m_pc = lnd + PCW'(n);
      m_mask = after >> n;
      m_fast = m_fast && is_loc(m_pc);
    end
  endtask

  task automatic clear_in();
    cmd_skip = 0; cmd_fskip = 0; cmd_exec = 0; cmd_arg = '0;
    br_take = 0; br_abs = 0; br_target = '0;
    dec_wr_en = 0; dec_flag_en = 0;
  endtask

  task automatic slot();
    #1;
    model_check_and_step();
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_pc = '0; m_mask = '0; m_fast = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset pc", pc, 0);
    chk("R1 reset cancel", slot_cancel, 0);
    chk("R1 reset active", skip_active, 0);

    clear_in(); cmd_fskip = 1; cmd_arg = 32'h3FD; dec_wr_en = 1; slot();
    clear_in(); dec_wr_en = 1; dec_flag_en = 1;
    chk("R6 first masked pc", pc, 1);
    chk("R6 first masked cancel", slot_cancel, 1);
    chk("R2 cancel gates wr", wr_en, 0);
    slot();
    clear_in(); chk("R4 enabled pc", pc, 2); slot();
    clear_in(); chk("R5 run of eight pc", pc, 10);
    chk("R5 idle slot", slot_cancel, 1); slot();
    clear_in(); chk("R1 mask exhausted pc", pc, 11);
    chk("R1 mask exhausted", skip_active, 0);
    cmd_exec = 1; cmd_arg = (32'd2 << 9) | 32'd100; slot();
    clear_in(); chk("R7 exec target", pc, 100); chk("R7 target enabled", slot_cancel, 0); slot();
    clear_in(); chk("R4 fast skip one", pc, 102);
    cmd_fskip = 1; cmd_arg = 32'h4; slot();
    clear_in(); chk("R11 new load pc", pc, 103); slot();
    clear_in(); chk("R9 before abs", pc, 104);
    br_take = 1; br_abs = 1; br_target = 16'd200; #1;
    chk("R9 abs_err raised", abs_err, 1); slot();
    clear_in(); chk("R9 abs landing pc", pc, 200); chk("R9 abs landing cancelled", slot_cancel, 1);
    cmd_exec = 1; cmd_arg = 32'd300; slot();
    clear_in(); chk("R2 command ignored", pc, 201);
    cmd_fskip = 1; cmd_arg = 32'h6; slot();
    clear_in(); chk("R8 before rel", pc, 202);
    br_take = 1; br_target = 16'd400; slot();
    clear_in(); chk("R8 rel lands beyond", pc, 402);
    cmd_fskip = 1; cmd_arg = 32'hA; slot();
    clear_in(); br_take = 1; br_target = 16'd2000; slot();
    clear_in(); chk("R10 hub cancel", slot_cancel, 1); chk("R10 hub pc", pc, 2000); slot();
    clear_in(); br_take = 1; br_target = 16'd500; slot();
    clear_in(); chk("R10 back local no fast", pc, 500); chk("R10 cancelled", slot_cancel, 1); slot();
    clear_in(); cmd_skip = 1; cmd_arg = 32'h5; slot();
    clear_in(); chk("R3 plain cancel", slot_cancel, 1); chk("R3 plain pc", pc, 502); slot();
    clear_in(); chk("R3 plain step", pc, 503); slot();
    clear_in(); chk("R3 plain masked slot", pc, 504); chk("R3 cancelled", slot_cancel, 1);
    cmd_fskip = 1; cmd_skip = 1; cmd_exec = 1; cmd_arg = 32'd50; slot();
    clear_in(); chk("R11 priority ignored in cancel", pc, 505);
    cmd_fskip = 1; cmd_skip = 1; cmd_exec = 1; cmd_arg = (32'h1 << 9) | 32'd60; slot();
    clear_in(); chk("R11 exec wins", pc, 60); chk("R11 exec pattern", slot_cancel, 1); slot();

    for (int i = 0; i < 4000; i++) begin
      int r;
      clear_in();
      r = $urandom_range(0, 99);
      dec_wr_en = $urandom_range(0, 1);
      dec_flag_en = $urandom_range(0, 1);
      if (r < 10) begin
        cmd_arg = $urandom() & $urandom();
        case ($urandom_range(0, 2))
          0: cmd_skip = 1;
          1: cmd_fskip = 1;
          default: cmd_exec = 1;
        endcase
      end else if (r < 28) begin
        br_take = 1;
        br_abs = ($urandom_range(0, 2) == 0);
        br_target = ($urandom_range(0, 4) == 0) ? PCW'($urandom_range(1024, 4095))
                                                 : PCW'($urandom_range(0, 1023));
      end
      slot();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule